// File: doc/BRIEF.md
# Three-Channel Timer Event Flag Unit

This block is a 16-bit timer counter with three capture/compare channels. The counter advances on each cycle in which the tick enable is high, and it counts in one of three ways: free-running over the full range, modulo with channel 0's value as the terminal count, or up and then down between zero and channel 0's value. Each channel either compares its value with the counter or, on a rising edge of its capture input, latches the counter into its value register.

Every capture or compare event raises a one-cycle DMA trigger for its channel and sets a sticky event flag. The counting mode decides which event sets which flag. In up/down mode, channel 0's flag (when that channel compares) and the overflow flag both come from the turnaround at zero, not from the compare. A single interrupt request is raised while any channel flag is set whose mask bit is 1. Software clears flags by writing zeros to them.

Setup uses a single write port. Typical use: stop the counter with the idle mode, clear it, load the values and channel controls, then write a counting mode.

Top module: `tri_timer`

## Requirements
- R1: After reset the counter, all value registers, all flags, the interrupt and all DMA triggers are 0, the mode is idle and every channel is in capture mode with its mask at 0.
- R2: Writing wr_data[1:0] to address 0 sets the mode: 0 idle, 1 free-running, 2 modulo, 3 up/down. In idle the counter holds its value even with tick_en high. In free-running mode each tick adds 1, and a tick at 0xFFFF wraps the counter to 0 and sets the overflow flag.
- R3: In modulo mode a tick while the counter equals channel 0's value loads 0 and sets the overflow flag. Other ticks add 1.
- R4: In free-running and modulo modes, a tick while the counter equals the value of a channel in compare mode sets that channel's flag (ch_flag bit n for channel n).
- R5: In up/down mode (channel 0 value at least 1) the counter rises to channel 0's value and then falls to 0. A tick at 0 while falling turns it upward and sets the overflow flag, and it also sets channel 0's flag if channel 0 is in compare mode. A compare match on channel 0 sets no flag in this mode. Channels 1 and 2 set their flags on compare matches, in either direction.
- R6: A channel in capture mode, in any non-idle mode, latches the counter into its value register and sets its flag on a rising edge of its capture input. The effect is seen three clock edges after the input rises. A channel in compare mode ignores its capture input.
- R7: irq is 1 exactly while some channel flag is set whose mask bit is 1. The overflow flag does not request an interrupt.
- R8: Flags are sticky. A write to address 8 clears each flag whose data bit is 0 (bits 0 to 2 are the channels, bit 3 is overflow) and leaves the flags whose bit is 1 unchanged. A flag being set in the same cycle stays set.
- R9: dma_trig bit n is a one-cycle pulse on the edge after each compare match or capture of channel n. Channel 0's trigger follows its compare match in every mode.
- R10: Any write to address 1 clears the counter to 0 on that edge and restarts up/down counting upward. Addresses 2 to 4 take the channel 0 to 2 controls (bit 0: 1 compare, 0 capture; bit 1: interrupt mask). Addresses 5 to 7 take the channel 0 to 2 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| tick_en | input | 1 | Counter tick enable |
| cap_in | input | 3 | Asynchronous capture inputs, one per channel |
| count | output | 16 | Current counter value |
| cc_val | output | 48 | Channel value registers, channel n at bits 16n+15:16n |
| ch_flag | output | 3 | Sticky channel event flags |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Combined interrupt request |
| dma_trig | output | 3 | One-cycle DMA triggers, one per channel |

## Verification
A register write takes effect on the edge that samples it. The count, flags and DMA triggers for a tick are due on that tick's own edge. The irq output follows the flags and masks in the same cycle, and a capture shows three edges after its input rises. The bench drives inputs and samples outputs one nanosecond after a rising edge. It counts the ticks and the synchronizer edges explicitly before each check, and it reads a DMA pulse on the edge it is due and checks again one cycle later that the pulse has gone.

// File: rtl/tmr_pkg.sv
// Package: shared types for the three-channel timer.
// Assumes: the mode encoding below is what software writes to address 0.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_FREE = 2'd1,
        MODE_MOD  = 2'd2,
        MODE_UPDN = 2'd3
    } tmode_e;
endpackage

// File: rtl/tmr_counter.sv
// Counter core: advances on each tick in the selected mode and flags the
// terminal-count wrap (free/modulo) and the zero turnaround (up/down).
// Assumes: term >= 1 in up/down mode; clr has priority over counting.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmode_e       mode,
    input  logic         tick_en,
    input  logic         clr,
    input  logic [W-1:0] term,
    output logic [W-1:0] count,
    output logic         run,
    output logic         wrap_evt,
    output logic         zero_evt
);
    logic         dir_up;
    logic         dir_nxt;
    logic [W-1:0] cnt_nxt;

    assign run = tick_en && (mode != MODE_IDLE);

    // Next-state and event decode for the current mode.
    always_comb begin
        cnt_nxt  = count;
        dir_nxt  = dir_up;
        wrap_evt = 1'b0;
        zero_evt = 1'b0;
        if (run) begin
            case (mode)
                MODE_FREE: begin
                    cnt_nxt  = count + W'(1);
                    wrap_evt = (count == '1);
                end
                MODE_MOD: begin
                    if (count == term) begin
                        cnt_nxt  = '0;
                        wrap_evt = 1'b1;
                    end else begin
                        cnt_nxt = count + W'(1);
                    end
                end
                MODE_UPDN: begin
                    if (dir_up) begin
                        if (count >= term) begin
                            dir_nxt = 1'b0;
                            cnt_nxt = count - W'(1);
                        end else begin
                            cnt_nxt = count + W'(1);
                        end
                    end else if (count == '0) begin
                        dir_nxt  = 1'b1;
                        cnt_nxt  = W'(1);
                        zero_evt = 1'b1;
                    end else begin
                        cnt_nxt = count - W'(1);
                    end
                end
                default: cnt_nxt = count;
            endcase
        end
    end

    // Counter and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count  <= '0;
            dir_up <= 1'b1;
        end else begin
            count  <= cnt_nxt;
            dir_up <= dir_nxt;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// One capture/compare channel: synchronizes its capture input, detects
// rising edges, latches the counter on capture and matches on compare.
// Assumes: a capture in the same cycle as a value write wins.
module tmr_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  logic         cmp_sel,
    input  logic         armed,
    input  logic         run,
    input  logic [W-1:0] count,
    input  logic         wr_val,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cc,
    output logic         cmp_evt,
    output logic         cap_evt
);
    logic [2:0] sync_q;

    // Two-flop synchronizer plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], cap_in};
    end

    assign cap_evt = sync_q[1] && !sync_q[2] && !cmp_sel && armed;
    assign cmp_evt = run && cmp_sel && (count == cc);

    // Value register: loaded by capture or by software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cc <= '0;
        else if (cap_evt) cc <= count;
        else if (wr_val)  cc <= wr_data;
    end
endmodule

// File: rtl/tmr_flags.sv
// Flag unit: maps channel and counter events to sticky flags by mode,
// drives the masked interrupt and registers the per-channel DMA pulses.
// Assumes: a set in the same cycle as a clear keeps the flag set.
module tmr_flags #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           updn,
    input  logic           ch0_cmp,
    input  logic [NCH-1:0] cmp_evt,
    input  logic [NCH-1:0] cap_evt,
    input  logic           wrap_evt,
    input  logic           zero_evt,
    input  logic           clr_wr,
    input  logic [NCH:0]   clr_data,
    input  logic [NCH-1:0] mask,
    output logic [NCH-1:0] ch_flag,
    output logic           ovf_flag,
    output logic           irq,
    output logic [NCH-1:0] dma_trig
);
    logic [NCH-1:0] ch_set;
    logic           ovf_set;
    logic [NCH:0]   keep;

    // Event-to-flag mapping; up/down moves channel 0 to the zero turnaround.
    always_comb begin
        for (int n = 0; n < NCH; n++) ch_set[n] = cmp_evt[n] | cap_evt[n];
        if (updn) ch_set[0] = ch0_cmp ? zero_evt : cap_evt[0];
        ovf_set = updn ? zero_evt : wrap_evt;
        keep    = clr_wr ? clr_data : '1;
    end

    // Sticky flags and one-cycle DMA triggers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_flag  <= '0;
            ovf_flag <= 1'b0;
            dma_trig <= '0;
        end else begin
            ch_flag  <= ch_set | (ch_flag & keep[NCH-1:0]);
            ovf_flag <= ovf_set | (ovf_flag & keep[NCH]);
            dma_trig <= cmp_evt | cap_evt;
        end
    end

    assign irq = |(ch_flag & mask);
endmodule

// File: rtl/tri_timer.sv
// Top: three-channel timer with mode-dependent event flags. Decodes the
// write port into mode, channel controls and values, and ties the counter,
// channels and flag unit together.
// Assumes: W >= NCH + 1 so the flag-clear bits fit in wr_data.
module tri_timer
    import tmr_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 3,
    parameter int AW  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic             tick_en,
    input  logic [NCH-1:0]   cap_in,
    output logic [W-1:0]     count,
    output logic [NCH*W-1:0] cc_val,
    output logic [NCH-1:0]   ch_flag,
    output logic             ovf_flag,
    output logic             irq,
    output logic [NCH-1:0]   dma_trig
);
    localparam int ADR_MODE = 0;
    localparam int ADR_CNT  = 1;
    localparam int ADR_CTL  = 2;
    localparam int ADR_VAL  = ADR_CTL + NCH;
    localparam int ADR_FLG  = ADR_VAL + NCH;

    tmode_e         mode_q;
    logic [NCH-1:0] cmp_sel_q;
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] cmp_evt;
    logic [NCH-1:0] cap_evt;
    logic           run;
    logic           wrap_evt;
    logic           zero_evt;
    logic           clr_cnt;

    assign clr_cnt = wr_en && (wr_addr == AW'(ADR_CNT));

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   mode_q <= MODE_IDLE;
        else if (wr_en && wr_addr == AW'(ADR_MODE))   mode_q <= tmode_e'(wr_data[1:0]);
    end

    tmr_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .tick_en  (tick_en),
        .clr      (clr_cnt),
        .term     (cc_val[W-1:0]),
        .count    (count),
        .run      (run),
        .wrap_evt (wrap_evt),
        .zero_evt (zero_evt)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        // Per-channel control register: compare select and interrupt mask.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_sel_q[n] <= 1'b0;
                mask_q[n]    <= 1'b0;
            end else if (wr_en && wr_addr == AW'(ADR_CTL + n)) begin
                cmp_sel_q[n] <= wr_data[0];
                mask_q[n]    <= wr_data[1];
            end
        end

        tmr_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_in  (cap_in[n]),
            .cmp_sel (cmp_sel_q[n]),
            .armed   (mode_q != MODE_IDLE),
            .run     (run),
            .count   (count),
            .wr_val  (wr_en && wr_addr == AW'(ADR_VAL + n)),
            .wr_data (wr_data),
            .cc      (cc_val[n*W +: W]),
            .cmp_evt (cmp_evt[n]),
            .cap_evt (cap_evt[n])
        );
    end

    tmr_flags #(.NCH(NCH)) u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .updn     (mode_q == MODE_UPDN),
        .ch0_cmp  (cmp_sel_q[0]),
        .cmp_evt  (cmp_evt),
        .cap_evt  (cap_evt),
        .wrap_evt (wrap_evt),
        .zero_evt (zero_evt),
        .clr_wr   (wr_en && wr_addr == AW'(ADR_FLG)),
        .clr_data (wr_data[NCH:0]),
        .mask     (mask_q),
        .ch_flag  (ch_flag),
        .ovf_flag (ovf_flag),
        .irq      (irq),
        .dma_trig (dma_trig)
    );
endmodule

// File: rtl/tmr_checker.sv
// Checker: temporal properties of the timer, attached to tri_timer by bind.
// Assumes: it sees the top's ports plus its mode and mask registers.
module tmr_checker #(
    parameter int W   = 16,
    parameter int NCH = 3,
    parameter int AW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [AW-1:0]  wr_addr,
    input logic [NCH:0]   clr_bits,
    input logic           tick_en,
    input logic [1:0]     mode_q,
    input logic [NCH-1:0] mask_q,
    input logic [W-1:0]   count,
    input logic [W-1:0]   cc0,
    input logic [NCH-1:0] ch_flag,
    input logic           ovf_flag,
    input logic           irq,
    input logic [NCH-1:0] dma_trig
);
    localparam int ADR_CNT = 1;
    localparam int ADR_FLG = 2 + 2 * NCH;

    logic cnt_wr;
    logic flg_wr;
    assign cnt_wr = wr_en && (wr_addr == AW'(ADR_CNT));
    assign flg_wr = wr_en && (wr_addr == AW'(ADR_FLG));

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == '0)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0 && !cnt_wr) |=> $stable(count)); // R2

    AST_MOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd2 && tick_en && count == cc0 && !cnt_wr) |=> (count == '0 && ovf_flag)); // R3

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ch_flag != '0)); // R7

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(flg_wr && !clr_bits[NCH])); // R8

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_flag[n]) |-> $past(flg_wr && !clr_bits[n])); // R8

        AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            dma_trig[n] |=> !dma_trig[n]); // R9
    end
endmodule

bind tri_timer tmr_checker #(.W(W), .NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .clr_bits (wr_data[NCH:0]),
    .tick_en  (tick_en),
    .mode_q   (mode_q),
    .mask_q   (mask_q),
    .count    (count),
    .cc0      (cc_val[W-1:0]),
    .ch_flag  (ch_flag),
    .ovf_flag (ovf_flag),
    .irq      (irq),
    .dma_trig (dma_trig)
);

// File: tb/test_tri_timer.sv
module test_tri_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tick_en = 1'b0;
    logic [2:0]  cap_in = '0;
    logic [15:0] count;
    logic [47:0] cc_val;
    logic [2:0]  ch_flag;
    logic        ovf_flag;
    logic        irq;
    logic [2:0]  dma_trig;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    tri_timer i_tri_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_en(tick_en), .cap_in(cap_in),
        .count(count), .cc_val(cc_val), .ch_flag(ch_flag),
        .ovf_flag(ovf_flag), .irq(irq), .dma_trig(dma_trig)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] v0;
        logic [15:0] v1;
        logic [15:0] v2;
        logic [19:0] nticks;
        logic [15:0] exp_cnt;
        logic [2:0]  exp_ch;
        logic        exp_ovf;
    } vec_t;

    // mode, ch0..2 values, ticks, expected count, channel flags, overflow
    localparam vec_t VECS [6] = '{
        '{2'd1, 16'd5,    16'd3,    16'd100, 20'd4,     16'd4, 3'b010, 1'b0}, // R4 free
        '{2'd2, 16'd5,    16'd3,    16'd7,   20'd6,     16'd0, 3'b011, 1'b1}, // R3 R4 modulo wrap
        '{2'd2, 16'd5,    16'd2,    16'd4,   20'd5,     16'd5, 3'b110, 1'b0}, // R4 modulo no wrap
        '{2'd3, 16'd4,    16'd2,    16'd6,   20'd9,     16'd1, 3'b011, 1'b1}, // R5 zero turnaround
        '{2'd3, 16'd4,    16'd3,    16'd4,   20'd8,     16'd0, 3'b110, 1'b0}, // R5 ch0 match ignored
        '{2'd1, 16'h8000, 16'hFFFF, 16'd0,   20'd65536, 16'd0, 3'b111, 1'b1}  // R2 free wrap
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 count", count, 16'd0);
        chk("R1 values", 16'(|cc_val), 16'd0);
        chk("R1 flags", {12'd0, ovf_flag, ch_flag}, 16'd0);
        chk("R1 irq", 16'(irq), 16'd0);
        chk("R1 dma", 16'(dma_trig), 16'd0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            wr(4'd0, 16'd0);
            wr(4'd8, 16'd0);
            wr(4'd1, 16'd0);
            wr(4'd5, VECS[i].v0);
            wr(4'd6, VECS[i].v1);
            wr(4'd7, VECS[i].v2);
            wr(4'd2, 16'd1);
            wr(4'd3, 16'd1);
            wr(4'd4, 16'd1);
            wr(4'd0, 16'(VECS[i].mode));
            ticks(int'(VECS[i].nticks));
            chk($sformatf("R2 R3 R5 vec%0d count", i), count, VECS[i].exp_cnt);
            chk($sformatf("R4 R5 vec%0d ch_flag", i), 16'(ch_flag), 16'(VECS[i].exp_ch));
            chk($sformatf("R2 R3 R5 vec%0d ovf", i), 16'(ovf_flag), 16'(VECS[i].exp_ovf));
        end

        // R9: DMA pulse on the match edge, gone a cycle later
        wr(4'd0, 16'd0);
        wr(4'd8, 16'd0);
        wr(4'd1, 16'd0);
        wr(4'd5, 16'd10);
        wr(4'd6, 16'd2);
        wr(4'd7, 16'd100);
        wr(4'd0, 16'd2);
        ticks(3);
        chk("R9 dma pulse", 16'(dma_trig), 16'b010);
        chk("R10 count after ticks", count, 16'd3);
        idle(1);
        chk("R9 dma gone", 16'(dma_trig), 16'b000);
        chk("R8 flag sticky", 16'(ch_flag), 16'b010);

        // R7: interrupt follows mask
        chk("R7 masked irq", 16'(irq), 16'd0);
        wr(4'd3, 16'd3);
        chk("R7 unmasked irq", 16'(irq), 16'd1);
        // R8: writing ones leaves flags, writing zero clears
        wr(4'd8, 16'h000F);
        chk("R8 write ones", 16'(ch_flag), 16'b010);
        wr(4'd8, 16'h000D);
        chk("R8 write zero", 16'(ch_flag), 16'b000);
        chk("R7 irq after clear", 16'(irq), 16'd0);

        // R2: idle holds
        wr(4'd0, 16'd0);
        ticks(4);
        chk("R2 idle hold", count, 16'd3);
        // R10: counter write clears
        wr(4'd1, 16'd0);
        chk("R10 counter clear", count, 16'd0);

        // R6: capture on channel 2, channel 1 in compare ignores its input
        wr(4'd4, 16'd0);
        wr(4'd0, 16'd1);
        ticks(7);
        cap_in = 3'b110;
        idle(2);
        chk("R6 capture not yet", 16'(dma_trig), 16'b000);
        idle(1);
        chk("R6 R9 capture dma", 16'(dma_trig), 16'b100);
        chk("R6 capture flag", 16'(ch_flag[2]), 16'd1);
        chk("R6 captured value", cc_val[32 +: 16], 16'd7);
        chk("R6 compare channel ignores input", cc_val[16 +: 16], 16'd2);
        idle(1);
        chk("R9 capture dma gone", 16'(dma_trig), 16'b000);
        cap_in = 3'b000;

        // R5 R6: up/down with channel 0 capturing
        wr(4'd0, 16'd0);
        wr(4'd8, 16'd0);
        wr(4'd1, 16'd0);
        wr(4'd5, 16'd2);
        wr(4'd2, 16'd0);
        wr(4'd3, 16'd1);
        wr(4'd4, 16'd1);
        wr(4'd0, 16'd3);
        ticks(5);
        chk("R5 updown count", count, 16'd1);
        chk("R5 updown ovf", 16'(ovf_flag), 16'd1);
        chk("R5 updown ch flags", 16'(ch_flag), 16'b010);
        cap_in = 3'b001;
        idle(3);
        chk("R6 updown capture flag", 16'(ch_flag), 16'b011);
        chk("R6 updown captured value", cc_val[15:0], 16'd1);
        cap_in = 3'b000;
        idle(2);

        finish_run();
    end
endmodule